// File: doc/BRIEF.md
# Delta-Sigma ADC Result Capture and Error Status

This block sits behind the decimation filters of a delta-sigma converter. Every end-of-conversion strobe captures the filtered sample into a readable data register. The sample is shown either as straight binary or as two's complement, chosen by a polarity bit. Out-of-range samples saturate to the limits of the chosen coding. A completion flag shows that a fresh result is waiting.

While a conversion runs, the block collects overflow (clip) pulses from two filters, the third-order sinc filter and the fast filter. It flags an overrun when a new result arrives before software has acknowledged the previous one, and it records a calibration result that fell outside the correction register limits. All of these are sticky, and they are combined into one summary error output. Software reads and clears the flags through a small register port with a combinational read path.

Top module: `adc_result_status`

## Requirements
- R1: Status bit 0 (done) is set by the cycle after `eocStb`. It clears when status (address 1) is written with bit 0 = 0. If a set and a clear fall in the same cycle, done stays set.
- R2: Status bit 1 goes to 1 the cycle after any `sinc3Clip` pulse and stays set.
- R3: Status bit 2 goes to 1 the cycle after any `fastClip` pulse and stays set.
- R4: Status bit 3 (overrun) is set when `eocStb` arrives while done is still 1, including when a clear of done is written in that same cycle.
- R5: Status bit 4 goes to 1 the cycle after `calOutOfRange` and stays set.
- R6: Writing 0 to bits 1..4 of status clears those flags. Writing 1 leaves them unchanged. An event in the same cycle as a clear leaves the flag set.
- R7: `errFlag` and status bit 5 are 1 exactly when any of status bits 1..4 is 1.
- R8: The data register (address 2) takes a new code at every `eocStb`, whether or not any error flag is set. On overrun, the older result is overwritten. With no `eocStb`, the data register holds its value.
- R9: With control bit 0 (address 0) = 0, the code is unipolar straight binary equal to `sampleIn`, which counts LSBs of VREF/2^RES_W. Values below 0 give 0, and values above 2^RES_W-1 give all ones.
- R10: With control bit 0 = 1, the code is two's complement of `sampleIn` arithmetically shifted right by one, saturated to -2^(RES_W-1) .. 2^(RES_W-1)-1. For example, at 24 bits, -VREF gives 0x800000, -VREF/2 gives 0xC00000, VREF/2 gives 0x400000 and VREF-1 LSB gives 0x7FFFFF.
- R11: Parameter `RES_W` sets the result width (24 or 16). `sampleIn` is RES_W+2 bits wide, and the same coding rules scale to the chosen width.
- R12: After reset, all flags, the polarity bit and the data register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eocStb | input | 1 | End-of-conversion strobe, one cycle |
| sampleIn | input | RES_W+2 | Signed filtered sample in LSBs of VREF/2^RES_W |
| sinc3Clip | input | 1 | Sinc filter overflow pulse |
| fastClip | input | 1 | Fast filter overflow pulse |
| calOutOfRange | input | 1 | Calibration result beyond correction limits |
| regAddr | input | 2 | Register address: 0 control, 1 status, 2 data |
| regWe | input | 1 | Register write enable |
| regWdata | input | 8 | Register write data |
| regRdata | output | RES_W | Combinational read data for `regAddr` |
| doneFlag | output | 1 | Conversion-complete flag |
| errFlag | output | 1 | Summary error flag |

## Verification
The formatting path is driven with in-range samples at the zero, half-scale and full-scale code points in both polarities, and with samples beyond both ends. These show scaling, sign handling and saturation apart. The flag logic is driven with isolated pulses, with repeated strobes that have no acknowledge, and with events that land in the same cycle as a clear write. These show whether a flag set and a clear are ordered correctly. A write of ones to status shows that a 1 does not clear a flag.

// File: rtl/adc_rs_pkg.sv
package adc_rs_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2
  } reg_addr_e;

  localparam int ST_DONE = 0;
  localparam int ST_S3   = 1;
  localparam int ST_FF   = 2;
  localparam int ST_OVR  = 3;
  localparam int ST_CAL  = 4;
  localparam int ST_ERR  = 5;
  localparam int ST_BITS = 6;
  localparam int N_ERR   = 4;

  typedef struct packed {
    logic capture;
    logic polWe;
    logic polVal;
  } dp_strobe_t;
endpackage

// File: rtl/adc_rs_ctrl.sv
module adc_rs_ctrl
  import adc_rs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               eocStb,
  input  logic               sinc3Clip,
  input  logic               fastClip,
  input  logic               calOutOfRange,
  input  logic [1:0]         regAddr,
  input  logic               regWe,
  input  logic [7:0]         regWdata,
  output dp_strobe_t         dpStb,
  output logic [ST_BITS-1:0] statusVec,
  output logic               doneFlag,
  output logic               errFlag
);
  logic             doneQ;
  logic [N_ERR-1:0] errQ;
  logic [N_ERR-1:0] errEvt;
  logic [N_ERR-1:0] errClr;
  logic             statWr;
  logic             doneClr;

  always_comb begin
    statWr  = regWe && (regAddr == ADDR_STAT);
    doneClr = statWr && !regWdata[ST_DONE];
    // event order follows status bits 1..4
    errEvt  = {calOutOfRange, eocStb && doneQ, fastClip, sinc3Clip};
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= eocStb | (doneQ & ~doneClr);
  end

  for (genvar i = 0; i < N_ERR; i++) begin : g_sticky
    assign errClr[i] = statWr && !regWdata[i+1];
    always_ff @(posedge clk) begin
      if (!rstN) errQ[i] <= 1'b0;
      else       errQ[i] <= errEvt[i] | (errQ[i] & ~errClr[i]);
    end
  end

  always_comb begin
    dpStb.capture = eocStb;
    dpStb.polWe   = regWe && (regAddr == ADDR_CTRL);
    dpStb.polVal  = regWdata[0];
    doneFlag      = doneQ;
    errFlag       = |errQ;
    statusVec     = {errFlag, errQ, doneQ};
  end
endmodule

// File: rtl/adc_rs_datapath.sv
module adc_rs_datapath
  import adc_rs_pkg::*;
#(
  parameter int RES_W = 24,
  parameter int RAW_W = RES_W + 2
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  dp_strobe_t              dpStb,
  input  logic signed [RAW_W-1:0] sampleIn,
  output logic                    polarity,
  output logic [RES_W-1:0]        dataReg
);
  localparam int EXT_U = RAW_W - RES_W;
  localparam int EXT_B = RAW_W - RES_W + 1;
  localparam logic signed [RAW_W-1:0] U_MAX = {{EXT_U{1'b0}}, {RES_W{1'b1}}};
  localparam logic signed [RAW_W-1:0] B_MAX = {{EXT_B{1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic signed [RAW_W-1:0] B_MIN = {{EXT_B{1'b1}}, {(RES_W-1){1'b0}}};

  logic signed [RAW_W-1:0] halfS;
  logic [RES_W-1:0]        uniCode;
  logic [RES_W-1:0]        bipCode;
  logic [RES_W-1:0]        fmtCode;

  always_comb begin
    halfS = sampleIn >>> 1;
    if (sampleIn < 0)          uniCode = '0;
    else if (sampleIn > U_MAX) uniCode = '1;
    else                       uniCode = sampleIn[RES_W-1:0];
    if (halfS < B_MIN)         bipCode = {1'b1, {(RES_W-1){1'b0}}};
    else if (halfS > B_MAX)    bipCode = {1'b0, {(RES_W-1){1'b1}}};
    else                       bipCode = halfS[RES_W-1:0];
    fmtCode = polarity ? bipCode : uniCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polarity <= 1'b0;
      dataReg  <= '0;
    end else begin
      if (dpStb.polWe)   polarity <= dpStb.polVal;
      if (dpStb.capture) dataReg  <= fmtCode;
    end
  end
endmodule

// File: rtl/adc_result_status.sv
module adc_result_status
  import adc_rs_pkg::*;
#(
  parameter int RES_W = 24,
  parameter int RAW_W = RES_W + 2
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    eocStb,
  input  logic signed [RAW_W-1:0] sampleIn,
  input  logic                    sinc3Clip,
  input  logic                    fastClip,
  input  logic                    calOutOfRange,
  input  logic [1:0]              regAddr,
  input  logic                    regWe,
  input  logic [7:0]              regWdata,
  output logic [RES_W-1:0]        regRdata,
  output logic                    doneFlag,
  output logic                    errFlag
);
  dp_strobe_t         dpStb;
  logic [ST_BITS-1:0] statusVec;
  logic               polarity;
  logic [RES_W-1:0]   dataReg;

  adc_rs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .eocStb(eocStb), .sinc3Clip(sinc3Clip),
    .fastClip(fastClip), .calOutOfRange(calOutOfRange), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .dpStb(dpStb), .statusVec(statusVec),
    .doneFlag(doneFlag), .errFlag(errFlag)
  );

  adc_rs_datapath #(.RES_W(RES_W), .RAW_W(RAW_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .sampleIn(sampleIn),
    .polarity(polarity), .dataReg(dataReg)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = {{(RES_W-1){1'b0}}, polarity};
      ADDR_STAT: regRdata = {{(RES_W-ST_BITS){1'b0}}, statusVec};
      ADDR_DATA: regRdata = dataReg;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_rs_checker.sv
module adc_rs_checker #(
  parameter int RES_W = 24
)(
  input logic             clk,
  input logic             rstN,
  input logic             eocStb,
  input logic             sinc3Clip,
  input logic             fastClip,
  input logic             calOutOfRange,
  input logic [1:0]       regAddr,
  input logic             regWe,
  input logic [7:0]       regWdata,
  input logic [5:0]       statusVec,
  input logic [RES_W-1:0] dataReg,
  input logic             doneFlag,
  input logic             errFlag
);
  logic statWr;
  assign statWr = regWe && (regAddr == 2'd1);

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rstN) eocStb |=> doneFlag); // R1
  AST_SINC3_SET: assert property (@(posedge clk) disable iff (!rstN) sinc3Clip |=> statusVec[1]); // R2
  AST_FAST_SET: assert property (@(posedge clk) disable iff (!rstN) fastClip |=> statusVec[2]); // R3
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN) (eocStb && doneFlag) |=> statusVec[3]); // R4
  AST_CAL_SET: assert property (@(posedge clk) disable iff (!rstN) calOutOfRange |=> statusVec[4]); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN) (statusVec[1] && !(statWr && !regWdata[1])) |=> statusVec[1]); // R6
  AST_ERR_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN) $rose(errFlag) |-> $past(sinc3Clip || fastClip || calOutOfRange || (eocStb && doneFlag))); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN) !eocStb |=> $stable(dataReg)); // R8
endmodule

bind adc_result_status adc_rs_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .eocStb(eocStb), .sinc3Clip(sinc3Clip),
  .fastClip(fastClip), .calOutOfRange(calOutOfRange), .regAddr(regAddr),
  .regWe(regWe), .regWdata(regWdata), .statusVec(statusVec),
  .dataReg(dataReg), .doneFlag(doneFlag), .errFlag(errFlag)
);

// File: tb/sim_adc_result_status.sv
`timescale 1ns/1ps
module sim_adc_result_status;
  localparam int RES_W = 24;
  localparam int RAW_W = RES_W + 2;

  logic                    clk = 1'b0;
  logic                    rstN;
  logic                    eocStb;
  logic signed [RAW_W-1:0] sampleIn;
  logic                    sinc3Clip, fastClip, calOutOfRange;
  logic [1:0]              regAddr;
  logic                    regWe;
  logic [7:0]              regWdata;
  logic [RES_W-1:0]        regRdata;
  logic                    doneFlag, errFlag;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  adc_result_status #(.RES_W(RES_W), .RAW_W(RAW_W)) u0 (
    .clk(clk), .rstN(rstN), .eocStb(eocStb), .sampleIn(sampleIn),
    .sinc3Clip(sinc3Clip), .fastClip(fastClip), .calOutOfRange(calOutOfRange),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .doneFlag(doneFlag), .errFlag(errFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [RES_W-1:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic convert(input int s);
    @(negedge clk);
    sampleIn = RAW_W'(s); eocStb = 1'b1;
    @(negedge clk);
    eocStb = 1'b0;
  endtask

  task automatic convertCheck(input int s, input logic [RES_W-1:0] exp, input string req);
    logic [RES_W-1:0] v;
    writeReg(2'd1, 8'h00);
    convert(s);
    readReg(2'd2, v);
    check(req, 32'(v), 32'(exp));
  endtask

  task automatic testReset();
    logic [RES_W-1:0] v;
    readReg(2'd1, v); check("R12 status", 32'(v), 0);
    readReg(2'd0, v); check("R12 polarity", 32'(v), 0);
    readReg(2'd2, v); check("R12 data", 32'(v), 0);
    check("R12 outputs", {30'd0, doneFlag, errFlag}, 0);
  endtask

  task automatic testUnipolar();
    writeReg(2'd0, 8'h00);
    convertCheck(0, 24'h000000, "R9 zero");
    convertCheck(1 << 23, 24'h800000, "R9 half");
    convertCheck((1 << 24) - 1, 24'hFFFFFF, "R9 full");
    convertCheck(-5, 24'h000000, "R9 below zero saturates");
    convertCheck((1 << 24) + 7, 24'hFFFFFF, "R9 above full saturates");
  endtask

  task automatic testBipolar();
    logic [RES_W-1:0] v;
    writeReg(2'd0, 8'h01);
    readReg(2'd0, v); check("R10 polarity bit", 32'(v), 1);
    convertCheck(-(1 << 24), 24'h800000, "R10 minus full");
    convertCheck(-(1 << 23), 24'hC00000, "R10 minus half");
    convertCheck(0, 24'h000000, "R10 zero");
    convertCheck(1 << 23, 24'h400000, "R10 plus half");
    convertCheck((1 << 24) - 1, 24'h7FFFFF, "R10 R11 plus full");
    convertCheck(-(1 << 25), 24'h800000, "R10 low saturates");
    convertCheck((1 << 25) - 1, 24'h7FFFFF, "R10 high saturates");
    writeReg(2'd0, 8'h00);
  endtask

  task automatic testDone();
    logic [RES_W-1:0] v;
    writeReg(2'd1, 8'h00);
    convert(100);
    check("R1 done set", 32'(doneFlag), 1);
    writeReg(2'd1, 8'h3E);
    check("R1 done cleared", 32'(doneFlag), 0);
    @(negedge clk);
    regAddr = 2'd1; regWdata = 8'h00; regWe = 1'b1; eocStb = 1'b1; sampleIn = RAW_W'(200);
    @(negedge clk);
    regWe = 1'b0; eocStb = 1'b0;
    readReg(2'd1, v);
    check("R1 set beats clear", 32'(v[0]), 1);
    check("R4 no overrun when done was clear", 32'(v[3]), 0);
  endtask

  task automatic testOverrun();
    logic [RES_W-1:0] v;
    writeReg(2'd1, 8'h00);
    convert(1000);
    convert(2000);
    readReg(2'd1, v);
    check("R4 overrun flag", 32'(v[3]), 1);
    check("R7 err on overrun", {30'd0, errFlag, v[5]}, 3);
    readReg(2'd2, v);
    check("R8 newer result kept", 32'(v), 2000);
    convert(3000);
    readReg(2'd2, v);
    check("R8 update while error set", 32'(v), 3000);
    @(negedge clk);
    regAddr = 2'd1; regWdata = 8'h00; regWe = 1'b1; eocStb = 1'b1; sampleIn = RAW_W'(4000);
    @(negedge clk);
    regWe = 1'b0; eocStb = 1'b0;
    readReg(2'd1, v);
    check("R4 overrun when clear coincides", 32'(v[3]), 1);
    repeat (3) @(negedge clk);
    readReg(2'd2, v);
    check("R8 holds without strobe", 32'(v), 4000);
  endtask

  task automatic testClips();
    logic [RES_W-1:0] v;
    writeReg(2'd1, 8'h00);
    @(negedge clk); sinc3Clip = 1'b1;
    @(negedge clk); sinc3Clip = 1'b0;
    repeat (3) @(negedge clk);
    readReg(2'd1, v);
    check("R2 sinc clip sticky", 32'(v[5:0]), 32'h22);
    writeReg(2'd1, 8'hFF);
    readReg(2'd1, v);
    check("R6 write one keeps", 32'(v[1]), 1);
    writeReg(2'd1, 8'hFD);
    readReg(2'd1, v);
    check("R6 write zero clears", 32'(v[5:0]), 0);
    check("R7 err low after clear", 32'(errFlag), 0);
    @(negedge clk); fastClip = 1'b1;
    @(negedge clk); fastClip = 1'b0;
    readReg(2'd1, v);
    check("R3 fast clip", 32'(v[5:0]), 32'h24);
    @(negedge clk);
    regAddr = 2'd1; regWdata = 8'h00; regWe = 1'b1; fastClip = 1'b1;
    @(negedge clk);
    regWe = 1'b0; fastClip = 1'b0;
    readReg(2'd1, v);
    check("R6 event beats clear", 32'(v[5:0]), 32'h24);
  endtask

  task automatic testCal();
    logic [RES_W-1:0] v;
    writeReg(2'd1, 8'h00);
    @(negedge clk); calOutOfRange = 1'b1;
    @(negedge clk); calOutOfRange = 1'b0;
    readReg(2'd1, v);
    check("R5 cal flag", 32'(v[5:0]), 32'h30);
    check("R7 err on cal", 32'(errFlag), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; eocStb = 1'b0; sampleIn = '0; sinc3Clip = 1'b0; fastClip = 1'b0;
    calOutOfRange = 1'b0; regAddr = 2'd0; regWe = 1'b0; regWdata = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnipolar();
    testBipolar();
    testDone();
    testOverrun();
    testClips();
    testCal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule